// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets each core of a small multicore cluster interrupt another core and hand it a 16-bit message. Every core owns a pair of 32-bit registers on a plain register bus: a control word, which the core writes to send or to acknowledge, and a status word, which holds the last message delivered to that core. Each core also has one interrupt output from the block.

A sender writes its own control word with the send bit set, a destination core number and a 16-bit payload. The destination's status word is overwritten with a pending flag, the sender's number and the payload, and the destination's interrupt rises. The receiver reads its status word, then writes its own control word with the acknowledge bit set to drop the interrupt. A single control write can send and acknowledge at once. There is no queue. A newer message to the same core replaces the older one.

Top module: `ipi_ctrl`

## Requirements
- R1: Byte address bits [ADDR_W-1:3] select the core, and bit 2 selects the register: 0 is control, 1 is status. Core c therefore has control at 8*c and status at 8*c+4.
- R2: A write to a core's control register stores the whole 32-bit word. A read of that register returns the stored word.
- R3: A control write with bit 30 (send) set and a destination number in bits [29:16] overwrites the destination's status. The new status has bit 31 = 0, bit 30 (pending) = 1, bits [29:16] = the writer's core number, and bits [15:0] = the written bits [15:0].
- R4: Each interrupt output is registered and always equals bit 30 of that core's status. It rises on the clock edge that ends the send write.
- R5: A control write with bit 31 (acknowledge) set clears the writer's pending bit and interrupt. The writer's sender and payload fields are kept.
- R6: When send and acknowledge are set in the same write, the acknowledge is applied after the delivery. A core that sends to itself with both bits set ends with pending = 0, and its sender and payload fields hold the new message.
- R7: Writes to any status register change no status register and no interrupt.
- R8: An access whose core index is at or above NUM_CORES stores nothing and reads as zero. A send whose destination number is at or above NUM_CORES delivers nothing, but the control word is still stored.
- R9: Reset is asynchronous and active low, and its release is synchronised. While reset is active, and after it ends, every control word, status word and interrupt is zero.
- R10: A new message overwrites the destination's previous status, including a message that is still pending. Nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_CORES | Interrupt line for each core |

## Verification
The bench runs three cores and tries delivery with several pairings: core 0 to core 2, core 1 to core 2 while core 2's earlier message is still pending, core 2 to core 1, and cores that target themselves. These pairings show whether the sender field comes from the address of the write rather than from the data, and whether a second message replaces the first. Control words with only the acknowledge bit, with both bits, and with neither bit are compared. This tells a plain store apart from an acknowledge, and shows the order in which a combined write applies its two effects. Writes to status registers, an address index past the last core, and a destination past the last core check that nothing that should be ignored leaks into state.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W  = 32;
  localparam int CORE_NW = 14;
  localparam int MSG_W   = 16;

  typedef logic [CORE_NW-1:0] core_num_t;
  typedef logic [MSG_W-1:0]   msg_t;

  typedef struct packed {
    logic      ack;
    logic      send;
    core_num_t dst;
    msg_t      msg;
  } ctrl_word_t;

  typedef struct packed {
    logic      rsvd;
    logic      pend;
    core_num_t src;
    msg_t      msg;
  } stat_word_t;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 5,
  localparam int IDX_W    = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [WORD_W-1:0]    wdata,
  output logic [IDX_W-1:0]     idx,
  output logic                 idx_ok,
  output logic                 sel_stat,
  output core_num_t            src_num,
  output logic [NUM_CORES-1:0] ctrl_wr_vec,
  output logic [NUM_CORES-1:0] deliver_vec,
  output logic [NUM_CORES-1:0] ack_vec
);
  localparam logic [IDX_W:0]   IDX_LIM = NUM_CORES[IDX_W:0];
  localparam logic [CORE_NW:0] DST_LIM = NUM_CORES[CORE_NW:0];

  ctrl_word_t cw;
  logic       ctrl_wr;
  logic       dst_ok;

  always_comb begin
    cw       = ctrl_word_t'(wdata);
    idx      = addr[ADDR_W-1:3];
    sel_stat = addr[2];
    idx_ok   = ({1'b0, idx} < IDX_LIM);
    ctrl_wr  = we && !sel_stat && idx_ok;
    dst_ok   = ({1'b0, cw.dst} < DST_LIM);
    src_num  = CORE_NW'(idx);
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assign ctrl_wr_vec[i] = ctrl_wr && (idx == IDX_W'(i));
    assign ack_vec[i]     = ctrl_wr_vec[i] && cw.ack;
    assign deliver_vec[i] = ctrl_wr && cw.send && dst_ok && (cw.dst == CORE_NW'(i));
  end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              deliver,
  input  logic              ack,
  input  logic [WORD_W-1:0] wdata,
  input  core_num_t         src_num,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] stat_q,
  output logic              irq_q
);
  stat_word_t  stat_d;
  logic        stat_en;

  always_comb begin
    stat_d  = stat_word_t'(stat_q);
    stat_en = deliver || ack;
    if (deliver) begin
      stat_d.rsvd = 1'b0;
      stat_d.pend = 1'b1;
      stat_d.src  = src_num;
      stat_d.msg  = wdata[MSG_W-1:0];
    end
    if (ack) begin
      stat_d.pend = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else if (stat_en) begin
      stat_q <= stat_d;
      irq_q  <= stat_d.pend;
    end
  end
endmodule

// File: rtl/ipi_rd_mux.sv
module ipi_rd_mux
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int IDX_W     = 2
) (
  input  logic [IDX_W-1:0]            idx,
  input  logic                        idx_ok,
  input  logic                        sel_stat,
  input  logic [NUM_CORES*WORD_W-1:0] ctrl_flat,
  input  logic [NUM_CORES*WORD_W-1:0] stat_flat,
  output logic [WORD_W-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (idx_ok && (idx == IDX_W'(i))) begin
        rdata = sel_stat ? stat_flat[i*WORD_W +: WORD_W]
                         : ctrl_flat[i*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int IDX_W = ADDR_W - 3;

  logic                        rst_q_n;
  logic [IDX_W-1:0]            idx;
  logic                        idx_ok;
  logic                        sel_stat;
  core_num_t                   src_num;
  logic [NUM_CORES-1:0]        ctrl_wr_vec;
  logic [NUM_CORES-1:0]        deliver_vec;
  logic [NUM_CORES-1:0]        ack_vec;
  logic [NUM_CORES*WORD_W-1:0] ctrl_flat;
  logic [NUM_CORES*WORD_W-1:0] stat_flat;

  ipi_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ipi_addr_dec #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr        (bus_addr),
    .we          (bus_we),
    .wdata       (bus_wdata),
    .idx         (idx),
    .idx_ok      (idx_ok),
    .sel_stat    (sel_stat),
    .src_num     (src_num),
    .ctrl_wr_vec (ctrl_wr_vec),
    .deliver_vec (deliver_vec),
    .ack_vec     (ack_vec)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
    ipi_core_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .ctrl_wr (ctrl_wr_vec[i]),
      .deliver (deliver_vec[i]),
      .ack     (ack_vec[i]),
      .wdata   (bus_wdata),
      .src_num (src_num),
      .ctrl_q  (ctrl_flat[i*WORD_W +: WORD_W]),
      .stat_q  (stat_flat[i*WORD_W +: WORD_W]),
      .irq_q   (irq_o[i])
    );
  end

  ipi_rd_mux #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_rd (
    .idx       (idx),
    .idx_ok    (idx_ok),
    .sel_stat  (sel_stat),
    .ctrl_flat (ctrl_flat),
    .stat_flat (stat_flat),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk #(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_CORES-1:0] irq_o,
  input logic [NUM_CORES*32-1:0] ctrl_flat,
  input logic [NUM_CORES*32-1:0] stat_flat
);
  localparam int IDX_W = ADDR_W - 3;
  logic [IDX_W-1:0] a_idx;
  logic             a_ok;
  assign a_idx = bus_addr[ADDR_W-1:3];
  assign a_ok  = (int'(a_idx) < NUM_CORES);

  AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[2]) |=> ($stable(stat_flat) && $stable(irq_o))); // R7

  AST_OOR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !a_ok) |=> ($stable(stat_flat) && $stable(ctrl_flat))); // R8

  AST_OOR_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ok |-> (bus_rdata == 32'd0)); // R8

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] == stat_flat[i*32+30]); // R4

    AST_STAT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_flat[i*32+31]); // R3

    AST_CTRL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_addr[2] && a_idx == IDX_W'(i))
      |=> (ctrl_flat[i*32 +: 32] == $past(bus_wdata))); // R2

    AST_SEND_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_addr[2] && a_ok && bus_wdata[30] &&
       bus_wdata[29:16] == 14'(i) && !(bus_wdata[31] && a_idx == IDX_W'(i)))
      |=> (irq_o[i] && stat_flat[i*32 +: 16] == $past(bus_wdata[15:0]))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_addr[2] && a_idx == IDX_W'(i) && bus_wdata[31])
      |=> !irq_o[i]); // R5
  end
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .ctrl_flat (ctrl_flat),
  .stat_flat (stat_flat)
);

// File: tb/ipi_ctrl_tb.sv
`timescale 1ns/100ps
module ipi_ctrl_tb;
  localparam int NC = 3;
  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_o;

  int n_chk;
  int n_bad;
  bit done;

  ipi_ctrl #(.NUM_CORES(NC), .ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int core, input bit stat, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = AW'(core * 8 + (stat ? 4 : 0));
    bus_we    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int core, input bit stat, output logic [31:0] d);
    bus_addr = AW'(core * 8 + (stat ? 4 : 0));
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int c = 0; c < NC; c++) begin
      rd(c, 0, v); check("R9 ctrl after reset", v, 0);
      rd(c, 1, v); check("R9 status after reset", v, 0);
    end
    check("R9 irq after reset", 32'(irq_o), 0);
  endtask

  task automatic t_store();
    logic [31:0] v;
    wr(1, 0, 32'h0003_1234);
    rd(1, 0, v); check("R2 R1 ctrl store", v, 32'h0003_1234);
    rd(1, 1, v); check("R1 status untouched", v, 0);
    check("R2 no irq from plain store", 32'(irq_o), 0);
  endtask

  task automatic t_deliver();
    logic [31:0] v;
    wr(0, 0, 32'h4002_BEEF);
    rd(2, 1, v); check("R3 status of dest", v, 32'h4000_BEEF);
    check("R4 irq of dest", 32'(irq_o), 32'b100);
    wr(1, 0, 32'h4002_1111);
    rd(2, 1, v); check("R10 overwrite pending msg", v, 32'h4001_1111);
    check("R4 irq still up", 32'(irq_o), 32'b100);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(2, 0, 32'h8000_0000);
    rd(2, 1, v); check("R5 ack keeps fields", v, 32'h0001_1111);
    check("R5 irq dropped", 32'(irq_o), 0);
    rd(2, 0, v); check("R2 ack word stored", v, 32'h8000_0000);
  endtask

  task automatic t_stat_ignored();
    logic [31:0] v;
    wr(2, 0, 32'h4001_00AA);
    rd(1, 1, v); check("R3 src from addr", v, 32'h4002_00AA);
    wr(1, 1, 32'h0000_0000);
    wr(1, 1, 32'hC000_0000);
    rd(1, 1, v); check("R7 status write ignored", v, 32'h4002_00AA);
    check("R7 irq kept", 32'(irq_o), 32'b010);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(0, 0, 32'hC000_5555);
    rd(0, 1, v); check("R6 self send+ack", v, 32'h0000_5555);
    check("R6 irq0 low", 32'(irq_o), 32'b010);
    wr(1, 0, 32'hC000_7777);
    rd(0, 1, v); check("R6 cross send delivered", v, 32'h4001_7777);
    rd(1, 1, v); check("R6 cross ack applied", v, 32'h0002_00AA);
    check("R6 irq pattern", 32'(irq_o), 32'b001);
  endtask

  task automatic t_oor();
    logic [31:0] v;
    wr(3, 0, 32'h4000_0001);
    rd(3, 0, v); check("R8 oor ctrl reads zero", v, 0);
    rd(3, 1, v); check("R8 oor status reads zero", v, 0);
    rd(0, 1, v); check("R8 oor write no delivery", v, 32'h4001_7777);
    wr(2, 0, 32'h4003_0009);
    rd(2, 0, v); check("R8 ctrl stored with bad dst", v, 32'h4003_0009);
    check("R8 bad dst no irq change", 32'(irq_o), 32'b001);
  endtask

  task automatic t_reset_mid();
    logic [31:0] v;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async irq clear", 32'(irq_o), 0);
    rd(0, 1, v); check("R9 async status clear", v, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    n_chk = 0; n_bad = 0; done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_store();
    t_deliver();
    t_ack();
    t_stat_ignored();
    t_both();
    t_oor();
    t_reset_mid();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule